// File: doc/BRIEF.md
# Pipelined Point-Source Intensity Accumulator

This block adds up, for one observer position, the wave contributions of a set of stored source points. The contribution of a source is its amplitude scaled by the reciprocal of its distance to the observer, multiplied by the cosine of the phase that this distance produces. All arithmetic is fixed point. The distance-dependent functions (reciprocal distance and phase) and the cosine come from small RAM tables that the host fills through the same write port it uses to load the source points. Each source point holds unsigned x and y coordinates, a precomputed squared z separation and a 16-bit amplitude.

A run begins with a start pulse that carries the number of points, the observer x and y, and a quarter-period flag. The block then feeds one point per clock into an eight-stage pipeline. The stages are: absolute coordinate difference, squaring, sum of the x and y squares, addition of the z term, table lookup, cosine lookup and amplitude scaling, product, and accumulation. It then pulses done and presents the 32-bit sum. Only the fractional part of the phase is stored and used, so the cosine sees one period. When the quarter flag is set, a quarter period is added to that fraction, which gives the quadrature component.

Top module: `holo_accum`

## Requirements
- R1: While rst is high and after it is released, busy, done and result are 0 until a run completes.
- R2: A write with wr_en high stores wr_data at wr_addr in the array picked by wr_sel. The codes are 0 for the source points, 1 for the reciprocal-distance table, 2 for the phase table and 3 for the cosine table. A source word carries the amplitude in bits 15:0, the squared z separation in bits 23:16, x in bits 27:24 and y in bits 31:28.
- R3: For each point, the table address is the squared distance r2 = |x-ox|^2 + |y-oy|^2 + dz2, where ox and oy are the observer coordinates latched at start.
- R4: The phase table keeps only the low 8 bits of a written word, which are the fraction of a period. Bits 15:8 of the written word are ignored. The cosine table index is the top 6 bits of that fraction.
- R5: The amplitude term is v = (amp * inv) >> 16, where inv is the reciprocal-distance entry at r2.
- R6: Each point adds w = (c * v) >>> 15 to the sum, with c the cosine entry read as signed 16-bit. The sum is 32-bit two's complement.
- R7: With qshift latched high, 64 is added modulo 256 to the fraction before the cosine index is taken.
- R8: done pulses for one cycle on the (count+8)-th rising edge after the edge that accepts start. result updates on that same edge and holds until the next done. busy is high from the accepting edge up to that edge.
- R9: A start is ignored while busy is high, and also when count is 0 or above 16. Inputs changed after an accepted start do not alter the run.
- R10: A start given in the cycle where done is high is accepted, and the next run produces its own correct sum.
- R11: Only the first count stored points enter the sum; points held at higher addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table or point write strobe |
| wr_sel | input | 2 | Target array of the write |
| wr_addr | input | 10 | Write address |
| wr_data | input | 32 | Write data |
| start | input | 1 | Begin a run |
| count | input | 5 | Number of points in the run, 1 to 16 |
| obs_x | input | 4 | Observer x |
| obs_y | input | 4 | Observer y |
| qshift | input | 1 | Add a quarter period to the phase |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Accumulated sum of the last run |

## Verification
Two events can land in the same cycle. One is the completion of a run: done high and result loading. The other is the acceptance of a fresh start, which clears the accumulator. The bench provokes this overlap by raising start right after it has seen done high, across a sweep of every observer position. It judges the overlap in two ways. The old result must still be present just before the new done. The new run's sum must equal the value the bench computes from its own copies of the tables. A start poked in mid-run with different inputs, and starts with illegal counts, must leave the run's timing and sum untouched.

// File: rtl/holo_pkg.sv
`timescale 1ns/1ps
package holo_pkg;
    typedef enum logic [1:0] {
        SEL_SRC   = 2'd0,
        SEL_INV   = 2'd1,
        SEL_PHASE = 2'd2,
        SEL_COS   = 2'd3
    } wsel_e;
endpackage

// File: rtl/holo_lut.sv
`timescale 1ns/1ps
module holo_lut #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/holo_cos_index.sv
`timescale 1ns/1ps
module holo_cos_index #(
    parameter int PF_W   = 8,
    parameter int COS_AW = 6
) (
    input  logic [PF_W-1:0]   frac,
    input  logic              qs,
    output logic [COS_AW-1:0] idx
);
    logic [PF_W-1:0] quarter;
    logic [PF_W-1:0] turned;

    assign quarter = qs ? {2'b01, {(PF_W-2){1'b0}}} : '0;
    assign turned  = frac + quarter;
    assign idx     = COS_AW'(turned >> (PF_W - COS_AW));
endmodule

// File: rtl/holo_accum.sv
`timescale 1ns/1ps
module holo_accum
    import holo_pkg::*;
#(
    parameter int CW     = 4,
    parameter int AMP_W  = 16,
    parameter int NA_W   = 4,
    parameter int PF_W   = 8,
    parameter int COS_AW = 6,
    parameter int ACC_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [2*CW+1:0]               wr_addr,
    input  logic [AMP_W+4*CW-1:0]         wr_data,
    input  logic                          start,
    input  logic [NA_W:0]                 count,
    input  logic [CW-1:0]                 obs_x,
    input  logic [CW-1:0]                 obs_y,
    input  logic                          qshift,
    output logic                          busy,
    output logic                          done,
    output logic [ACC_W-1:0]              result
);
    localparam int DZ_W  = 2 * CW;
    localparam int R2_W  = 2 * CW + 2;
    localparam int SRC_W = AMP_W + DZ_W + 2 * CW;
    localparam int CNT_W = NA_W + 1;
    localparam int NPTS  = 1 << NA_W;
    localparam int W_W   = AMP_W + 2;
    localparam int PR_W  = 2 * AMP_W + 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [CW-1:0]    ox;
        logic [CW-1:0]    oy;
        logic             qs;
        logic             s1_v, s1_l;
        logic [CW-1:0]    s1_dx, s1_dy;
        logic [DZ_W-1:0]  s1_dz;
        logic [AMP_W-1:0] s1_a;
        logic             s2_v, s2_l;
        logic [2*CW-1:0]  s2_qx, s2_qy;
        logic [DZ_W-1:0]  s2_dz;
        logic [AMP_W-1:0] s2_a;
        logic             s3_v, s3_l;
        logic [2*CW:0]    s3_sxy;
        logic [DZ_W-1:0]  s3_dz;
        logic [AMP_W-1:0] s3_a;
        logic             s4_v, s4_l;
        logic [R2_W-1:0]  s4_r2;
        logic [AMP_W-1:0] s4_a;
        logic             s5_v, s5_l;
        logic [AMP_W-1:0] s5_inv;
        logic [PF_W-1:0]  s5_fr;
        logic [AMP_W-1:0] s5_a;
        logic             s6_v, s6_l;
        logic [AMP_W-1:0] s6_c;
        logic [AMP_W-1:0] s6_mag;
        logic             s7_v, s7_l;
        logic [W_W-1:0]   s7_w;
        logic             s8_l;
        logic [ACC_W-1:0] acc;
        logic             done;
        logic [ACC_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    logic [SRC_W-1:0]  src_rd;
    logic [AMP_W-1:0]  inv_rd;
    logic [PF_W-1:0]   ph_rd;
    logic [AMP_W-1:0]  cos_rd;
    logic [COS_AW-1:0] cos_idx;
    logic              accept;
    logic              issue;

    // table and point storage, one instance per array
    holo_lut #(.AW(NA_W), .DW(SRC_W)) u_src (
        .clk(clk), .we(wr_en && wr_sel == SEL_SRC), .waddr(wr_addr[NA_W-1:0]),
        .wdata(wr_data), .raddr(st_q.idx[NA_W-1:0]), .rdata(src_rd));
    holo_lut #(.AW(R2_W), .DW(AMP_W)) u_inv (
        .clk(clk), .we(wr_en && wr_sel == SEL_INV), .waddr(wr_addr),
        .wdata(wr_data[AMP_W-1:0]), .raddr(st_q.s4_r2), .rdata(inv_rd));
    holo_lut #(.AW(R2_W), .DW(PF_W)) u_phase (
        .clk(clk), .we(wr_en && wr_sel == SEL_PHASE), .waddr(wr_addr),
        .wdata(wr_data[PF_W-1:0]), .raddr(st_q.s4_r2), .rdata(ph_rd));
    holo_lut #(.AW(COS_AW), .DW(AMP_W)) u_cos (
        .clk(clk), .we(wr_en && wr_sel == SEL_COS), .waddr(wr_addr[COS_AW-1:0]),
        .wdata(wr_data[AMP_W-1:0]), .raddr(cos_idx), .rdata(cos_rd));

    holo_cos_index #(.PF_W(PF_W), .COS_AW(COS_AW)) u_cidx (
        .frac(st_q.s5_fr), .qs(st_q.qs), .idx(cos_idx));

    assign accept = start && !st_q.busy && count != '0 && count <= CNT_W'(NPTS);
    assign issue  = st_q.busy && st_q.idx < st_q.cnt;

    always_comb begin
        logic [CW-1:0] px, py;
        st_d = st_q;
        px   = src_rd[AMP_W+DZ_W +: CW];
        py   = src_rd[AMP_W+DZ_W+CW +: CW];

        // stage 1: absolute coordinate differences
        st_d.s1_v  = issue;
        st_d.s1_l  = issue && (st_q.idx == st_q.cnt - CNT_W'(1));
        st_d.s1_dx = (px >= st_q.ox) ? px - st_q.ox : st_q.ox - px;
        st_d.s1_dy = (py >= st_q.oy) ? py - st_q.oy : st_q.oy - py;
        st_d.s1_dz = src_rd[AMP_W +: DZ_W];
        st_d.s1_a  = src_rd[AMP_W-1:0];
        if (issue) begin
            st_d.idx = st_q.idx + CNT_W'(1);
        end

        // stage 2: squares
        st_d.s2_v  = st_q.s1_v;
        st_d.s2_l  = st_q.s1_l;
        st_d.s2_qx = {{CW{1'b0}}, st_q.s1_dx} * {{CW{1'b0}}, st_q.s1_dx};
        st_d.s2_qy = {{CW{1'b0}}, st_q.s1_dy} * {{CW{1'b0}}, st_q.s1_dy};
        st_d.s2_dz = st_q.s1_dz;
        st_d.s2_a  = st_q.s1_a;

        // stage 3: planar sum
        st_d.s3_v   = st_q.s2_v;
        st_d.s3_l   = st_q.s2_l;
        st_d.s3_sxy = {1'b0, st_q.s2_qx} + {1'b0, st_q.s2_qy};
        st_d.s3_dz  = st_q.s2_dz;
        st_d.s3_a   = st_q.s2_a;

        // stage 4: add squared z separation
        st_d.s4_v  = st_q.s3_v;
        st_d.s4_l  = st_q.s3_l;
        st_d.s4_r2 = {1'b0, st_q.s3_sxy} + {2'b00, st_q.s3_dz};
        st_d.s4_a  = st_q.s3_a;

        // stage 5: reciprocal distance and phase fraction lookups
        st_d.s5_v   = st_q.s4_v;
        st_d.s5_l   = st_q.s4_l;
        st_d.s5_inv = inv_rd;
        st_d.s5_fr  = ph_rd;
        st_d.s5_a   = st_q.s4_a;

        // stage 6: cosine lookup and amplitude scaling
        st_d.s6_v   = st_q.s5_v;
        st_d.s6_l   = st_q.s5_l;
        st_d.s6_c   = cos_rd;
        st_d.s6_mag = AMP_W'(({{AMP_W{1'b0}}, st_q.s5_a} *
                              {{AMP_W{1'b0}}, st_q.s5_inv}) >> AMP_W);

        // stage 7: signed product
        st_d.s7_v = st_q.s6_v;
        st_d.s7_l = st_q.s6_l;
        st_d.s7_w = W_W'(($signed({{(AMP_W+1){st_q.s6_c[AMP_W-1]}}, st_q.s6_c}) *
                          $signed({{(AMP_W+1){1'b0}}, st_q.s6_mag})) >>> (AMP_W-1));

        // stage 8: accumulate
        st_d.s8_l = st_q.s7_v && st_q.s7_l;
        if (st_q.s7_v) begin
            st_d.acc = st_q.acc + {{(ACC_W-W_W){st_q.s7_w[W_W-1]}}, st_q.s7_w};
        end

        // completion
        st_d.done = st_q.s8_l;
        if (st_q.s8_l) begin
            st_d.res  = st_q.acc;
            st_d.busy = 1'b0;
        end

        // new run
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.cnt  = count;
            st_d.ox   = obs_x;
            st_d.oy   = obs_y;
            st_d.qs   = qshift;
            st_d.acc  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.done |=> !st_q.done);
    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !st_q.done |-> $stable(st_q.res));
    p_tail_busy_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.s7_v |-> st_q.busy);
    p_clear_on_start_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> (st_q.acc == '0 && st_q.busy));
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (start && st_q.busy) |=> $stable(st_q.cnt));
    p_idx_bound_r11: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (st_q.idx <= st_q.cnt));
endmodule

// File: tb/holo_accum_bench.sv
`timescale 1ns/1ps
module holo_accum_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [4:0]  count = '0;
    logic [3:0]  obs_x = '0;
    logic [3:0]  obs_y = '0;
    logic        qshift = 1'b0;
    logic        busy, done;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    logic [31:0] last_exp = '0;

    int sx [16];
    int sy [16];
    int sdz [16];
    int sa [16];
    int inv_t [1024];
    int ph_t [1024];
    int cos_t [64];

    always #4 clk = ~clk;

    holo_accum u_holo_accum (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .count(count), .obs_x(obs_x),
        .obs_y(obs_y), .qshift(qshift), .busy(busy), .done(done), .result(result));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sum(input int ox, input int oy, input int n, input int q);
        longint acc = 0;
        for (int j = 0; j < n; j++) begin
            int dx = (sx[j] > ox) ? sx[j] - ox : ox - sx[j];
            int dy = (sy[j] > oy) ? sy[j] - oy : oy - sy[j];
            int r2 = dx * dx + dy * dy + sdz[j];
            int fr = ph_t[r2] & 255;
            longint c, v, p;
            if (q != 0) fr = (fr + 64) & 255;
            c = cos_t[fr >> 2];
            if (c >= 32768) c = c - 65536;
            v = (longint'(sa[j]) * longint'(inv_t[r2])) >> 16;
            p = c * v;
            acc = acc + (p >>> 15);
        end
        return acc[31:0];
    endfunction

    task automatic wr(input int sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 2'(sel);
        wr_addr = 10'(addr);
        wr_data = 32'(data);
    endtask

    // called between edges; drives start, waits for done and checks result
    task automatic run_core(input int ox, input int oy, input int n, input int q, input bit poke);
        logic [31:0] e;
        e = exp_sum(ox, oy, n, q);
        obs_x = 4'(ox); obs_y = 4'(oy); count = 5'(n); qshift = q[0]; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        if (poke) begin
            obs_x = ~obs_x; obs_y = ~obs_y; qshift = ~qshift; count = 5'd1; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            repeat (n + 6) @(posedge clk);
        end else begin
            repeat (n + 7) @(posedge clk);
        end
        #1;
        chk(done == 1'b0, "R8 done not early", done, 0);
        chk(result == last_exp, "R8 result held", result, last_exp);
        @(posedge clk); #1;
        chk(done == 1'b1, "R8 done timing", done, 1);
        chk(result == e, poke ? "R9 poke ignored" : "R3 R4 R5 R6 R7 R11 sum", result, e);
        last_exp = e;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int j = 0; j < 16; j++) begin
            sx[j] = (j * 5 + 3) % 16;
            sy[j] = (j * 11 + 7) % 16;
            sdz[j] = (j * 29) % 256;
            sa[j] = (j * 4099 + 321) & 16'hFFFF;
        end
        for (int r = 0; r < 1024; r++) begin
            inv_t[r] = (r * 613 + 97) & 16'hFFFF;
            ph_t[r] = (r * 2711 + r * r) & 16'hFFFF;
        end
        for (int i = 0; i < 64; i++) cos_t[i] = (i * 1237 + 5000) % 65536;

        repeat (3) @(posedge clk);
        #1;
        chk(busy == 0 && done == 0 && result == 0, "R1 reset state", result, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(busy == 0 && done == 0 && result == 0, "R1 after release", result, 0);

        // R2: load points and tables (phase words carry integer bits that must be dropped, R4)
        for (int j = 0; j < 16; j++)
            wr(0, j, sa[j] | (sdz[j] << 16) | (sx[j] << 24) | (sy[j] << 28));
        for (int r = 0; r < 1024; r++) wr(1, r, inv_t[r]);
        for (int r = 0; r < 1024; r++) wr(2, r, ph_t[r]);
        for (int i = 0; i < 64; i++) wr(3, i, cos_t[i]);
        @(negedge clk);
        wr_en = 1'b0;

        // full and single point runs, both phase modes
        @(negedge clk); run_core(0, 0, 16, 0, 1'b0);
        @(negedge clk); run_core(15, 15, 1, 1, 1'b0);
        @(negedge clk); run_core(7, 3, 16, 1, 1'b0);

        // R9: start in mid-run with altered inputs
        @(negedge clk); run_core(4, 9, 6, 0, 1'b1);

        // R9: illegal counts
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            count = (k == 0) ? 5'd0 : 5'd17; start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            repeat (12) @(posedge clk);
            #1;
            chk(busy == 0 && done == 0 && result == last_exp, "R9 bad count ignored", result, last_exp);
        end

        // R10 + sweep: every observer, back-to-back starts in the done cycle
        @(negedge clk);
        for (int ox = 0; ox < 16; ox++)
            for (int oy = 0; oy < 16; oy++)
                run_core(ox, oy, 1 + ((ox + oy) % 16), (ox ^ oy) & 1, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule